// File: doc/BRIEF.md
# Store-Ordered Write Buffer with Load Forwarding

This block sits between one core's load/store port and a single memory port. Stores enter a queue and go to memory one at a time, in the order the core issued them. A load does not wait for older stores. If the youngest queued store to the same word is present, the load takes its data from the queue. Otherwise the load reads memory, and the read goes ahead of any stores still queued. A fence request covers barriers, atomic swap, test-and-set and store-conditional. The core issues a fence before any of those operations, and the fence is held off until every queued store has been written to memory. A cache-flush request travels through the same queue as a store, so it keeps its place in the commit order.

The core side is a single request channel with valid/ready, an operation code, a word address and write data. Load results return on a separate response strobe. The memory side carries a request (valid/ready, command, address, write data) and a read-data return strobe. Queue depth, address width and data width are parameters. Depth must be a power of two, at least 2.

Top module: `store_order_buffer`

## Requirements
- R1: Every accepted store reaches the memory port as a write command (`mem_cmd` = 1) with the same address and data. Stores reach memory in the order they were accepted. While entries are queued and no read is waiting to issue, `mem_valid` is high.
- R2: A load (`req_op` = 0) whose address equals a queued store's address raises `rsp_valid` in the cycle after acceptance, without a memory access. When several queued stores match, `rsp_data` holds the data of the most recently accepted one.
- R3: A load with no matching queued store issues one memory read (`mem_cmd` = 0) to the load address in the cycle after acceptance. Its data is returned on `rsp_valid`/`rsp_data` in the cycle after `mem_rvalid`. Loads are accepted and completed while older stores are still queued.
- R4: While a read is waiting to issue, the memory request is that read and no queued entry is drained. At most one memory transaction is presented per cycle.
- R5: Stores (`req_op` = 1) and flushes (`req_op` = 2) are refused (`req_ready` low) when DEPTH entries are queued. Every request is refused while a memory read is outstanding.
- R6: A fence (`req_op` = 3) is refused until the queue is empty and no read is outstanding. When accepted, it causes no memory traffic.
- R7: A flush is queued in order with the stores and reaches memory as `mem_cmd` = 2 at its address. A load never forwards from a queued flush.
- R8: `idle` is high exactly when no store or flush is queued.
- R9: After reset, `idle` is high, `mem_valid` and `rsp_valid` are low, and loads are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_op | input | 2 | 0 load, 1 store, 2 flush, 3 fence |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Store data |
| rsp_valid | output | 1 | Load result strobe |
| rsp_data | output | DW | Load result |
| mem_valid | output | 1 | Memory request present |
| mem_ready | input | 1 | Memory takes the request this cycle |
| mem_cmd | output | 2 | 0 read, 1 write, 2 flush |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rvalid | input | 1 | Read data return strobe |
| mem_rdata | input | DW | Read data |
| idle | output | 1 | No stores or flushes queued |

## Verification
The hardest case needs a full queue while a load misses. The read must then overtake a blocked drain, and the load's value must come from memory as it stood before the queued stores landed. The bench reaches this by holding `mem_ready` low while stores fill the queue. It then sends a load to an address none of those stores touched, and only afterwards lets memory accept. Other directed runs make several queued stores to one address and a flush to the same address meet a later load. Long random phases with a narrow address range cover the wrap of the queue pointers.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_FLUSH = 2'd2,
    OP_FENCE = 2'd3
  } sb_op_e;

  typedef enum logic [1:0] {
    MC_READ  = 2'd0,
    MC_WRITE = 2'd1,
    MC_FLUSH = 2'd2
  } mem_cmd_e;

  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_ISSUE = 2'd1,
    RD_WAIT  = 2'd2
  } rd_state_e;
endpackage

// File: rtl/sb_queue.sv
module sb_queue #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = IW + 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [AW-1:0]              push_addr,
  input  logic [DW-1:0]              push_data,
  input  logic                       push_flush,
  input  logic                       pop,
  output logic [IW-1:0]              head_ptr,
  output logic [CW-1:0]              count,
  output logic [AW-1:0]              head_addr,
  output logic [DW-1:0]              head_data,
  output logic                       head_flush,
  output logic [DEPTH-1:0][AW-1:0]   slot_addr,
  output logic [DEPTH-1:0][DW-1:0]   slot_data,
  output logic [DEPTH-1:0]           slot_flush
);
  logic [IW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;
  logic [DEPTH-1:0][AW-1:0] addr_mem;
  logic [DEPTH-1:0][DW-1:0] data_mem;
  logic [DEPTH-1:0]         flush_mem;

  // Payload storage carries no reset; only the pointers do.
  always_ff @(posedge clk) begin
    if (push) begin
      addr_mem[wr_ptr]  <= push_addr;
      data_mem[wr_ptr]  <= push_data;
      flush_mem[wr_ptr] <= push_flush;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  assign head_ptr   = rd_ptr;
  assign count      = cnt_q;
  assign head_addr  = addr_mem[rd_ptr];
  assign head_data  = data_mem[rd_ptr];
  assign head_flush = flush_mem[rd_ptr];
  assign slot_addr  = addr_mem;
  assign slot_data  = data_mem;
  assign slot_flush = flush_mem;

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> (cnt_q < CW'(DEPTH)));
  a_r1_no_underflow: assert property (@(posedge clk) disable iff (rst)
    pop |-> (cnt_q != '0));
endmodule

// File: rtl/sb_fwd.sv
module sb_fwd #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = IW + 1
) (
  input  logic [IW-1:0]              head_ptr,
  input  logic [CW-1:0]              count,
  input  logic [DEPTH-1:0][AW-1:0]   slot_addr,
  input  logic [DEPTH-1:0][DW-1:0]   slot_data,
  input  logic [DEPTH-1:0]           slot_flush,
  input  logic [AW-1:0]              look_addr,
  output logic                       hit,
  output logic [DW-1:0]              hit_data
);
  logic [DEPTH-1:0] match;

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic [IW-1:0] age;
    assign age      = IW'(s) - head_ptr;
    assign match[s] = ({1'b0, age} < count) && !slot_flush[s]
                      && (slot_addr[s] == look_addr);
  end

  // Walk from oldest to youngest; a later match overrides an earlier one.
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (match[IW'(head_ptr + IW'(k))]) begin
        hit      = 1'b1;
        hit_data = slot_data[IW'(head_ptr + IW'(k))];
      end
    end
  end
endmodule

// File: rtl/sb_port_mux.sv
module sb_port_mux
  import sb_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          rd_issue,
  input  logic [AW-1:0] rd_addr,
  input  logic          drain_avail,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  input  logic          head_flush,
  input  logic          mem_ready,
  output logic          mem_valid,
  output logic [1:0]    mem_cmd,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          drain_fire
);
  always_comb begin
    mem_valid = 1'b0;
    mem_cmd   = MC_READ;
    mem_addr  = head_addr;
    mem_wdata = head_data;
    if (rd_issue) begin
      mem_valid = 1'b1;
      mem_cmd   = MC_READ;
      mem_addr  = rd_addr;
    end else if (drain_avail) begin
      mem_valid = 1'b1;
      mem_cmd   = head_flush ? MC_FLUSH : MC_WRITE;
    end
  end

  assign drain_fire = !rd_issue && drain_avail && mem_ready;
endmodule

// File: rtl/store_order_buffer.sv
module store_order_buffer
  import sb_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [1:0]    mem_cmd,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          idle
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = IW + 1;

  rd_state_e rd_state;
  logic [AW-1:0] rd_addr;
  logic rd_busy, rd_issue;

  logic [IW-1:0] head_ptr;
  logic [CW-1:0] count;
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_data;
  logic          head_flush;
  logic [DEPTH-1:0][AW-1:0] slot_addr;
  logic [DEPTH-1:0][DW-1:0] slot_data;
  logic [DEPTH-1:0]         slot_flush;

  logic fwd_hit;
  logic [DW-1:0] fwd_data;
  logic push, pop, load_acc, fence_acc, q_full, q_empty;

  assign rd_busy  = (rd_state != RD_IDLE);
  assign rd_issue = (rd_state == RD_ISSUE);
  assign q_full   = (count == CW'(DEPTH));
  assign q_empty  = (count == '0);
  assign idle     = q_empty;

  always_comb begin
    unique case (req_op)
      OP_LOAD:  req_ready = !rd_busy;
      OP_STORE,
      OP_FLUSH: req_ready = !rd_busy && !q_full;
      default:  req_ready = !rd_busy && q_empty;
    endcase
  end

  assign load_acc  = req_valid && req_ready && (req_op == OP_LOAD);
  assign fence_acc = req_valid && req_ready && (req_op == OP_FENCE);
  assign push      = req_valid && req_ready &&
                     ((req_op == OP_STORE) || (req_op == OP_FLUSH));

  sb_queue #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_queue (
    .clk        (clk),
    .rst        (rst),
    .push       (push),
    .push_addr  (req_addr),
    .push_data  ((req_op == OP_FLUSH) ? '0 : req_wdata),
    .push_flush (req_op == OP_FLUSH),
    .pop        (pop),
    .head_ptr   (head_ptr),
    .count      (count),
    .head_addr  (head_addr),
    .head_data  (head_data),
    .head_flush (head_flush),
    .slot_addr  (slot_addr),
    .slot_data  (slot_data),
    .slot_flush (slot_flush)
  );

  sb_fwd #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fwd (
    .head_ptr   (head_ptr),
    .count      (count),
    .slot_addr  (slot_addr),
    .slot_data  (slot_data),
    .slot_flush (slot_flush),
    .look_addr  (req_addr),
    .hit        (fwd_hit),
    .hit_data   (fwd_data)
  );

  sb_port_mux #(.AW(AW), .DW(DW)) u_mux (
    .rd_issue    (rd_issue),
    .rd_addr     (rd_addr),
    .drain_avail (!q_empty),
    .head_addr   (head_addr),
    .head_data   (head_data),
    .head_flush  (head_flush),
    .mem_ready   (mem_ready),
    .mem_valid   (mem_valid),
    .mem_cmd     (mem_cmd),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .drain_fire  (pop)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_state  <= RD_IDLE;
      rd_addr   <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (rd_state)
        RD_IDLE: begin
          if (load_acc) begin
            if (fwd_hit) begin
              rsp_valid <= 1'b1;
              rsp_data  <= fwd_data;
            end else begin
              rd_state <= RD_ISSUE;
              rd_addr  <= req_addr;
            end
          end
        end
        RD_ISSUE: if (mem_ready) rd_state <= RD_WAIT;
        RD_WAIT: begin
          if (mem_rvalid) begin
            rd_state  <= RD_IDLE;
            rsp_valid <= 1'b1;
            rsp_data  <= mem_rdata;
          end
        end
        default: rd_state <= RD_IDLE;
      endcase
    end
  end

  a_r2_hit_next_cycle: assert property (@(posedge clk) disable iff (rst)
    (load_acc && fwd_hit) |=> rsp_valid);
  a_r3_miss_reads: assert property (@(posedge clk) disable iff (rst)
    (load_acc && !fwd_hit) |=> (mem_valid && mem_cmd == MC_READ && mem_addr == $past(req_addr)));
  a_r4_read_first: assert property (@(posedge clk) disable iff (rst)
    (rd_state == RD_ISSUE) |-> !pop);
  a_r6_fence_quiet: assert property (@(posedge clk) disable iff (rst)
    fence_acc |-> !mem_valid);
endmodule

// File: tb/tb_store_order_buffer.sv
module tb_store_order_buffer;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic rsp_valid;
  logic [DW-1:0] rsp_data;
  logic mem_valid;
  logic mem_ready = 1'b0;
  logic [1:0] mem_cmd;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic mem_rvalid = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic idle;

  always #2 clk = ~clk;

  store_order_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_cmd(mem_cmd),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .idle(idle)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // Reference model state
  logic [AW-1:0] mq_a[$];
  logic [DW-1:0] mq_d[$];
  bit            mq_f[$];
  logic [DW-1:0] exp_rsp[$];
  logic [DW-1:0] bmem[16];
  bit busy = 0, rd_issue = 0, hit_due = 0, rv_next = 0;
  logic [AW-1:0] rd_q_addr = '0;
  logic [DW-1:0] rv_val = '0;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", what, act, exp, $time);
    end
  endtask

  task automatic step(input bit v, input logic [1:0] op, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input int p_ready);
    bit exp_ready, hit, fire;
    logic [DW-1:0] hv;
    @(negedge clk);
    // results of the previous edge
    if (hit_due) chk(rsp_valid === 1'b1, "R2 forwarded response one cycle after load", rsp_valid, 1);
    hit_due = 0;
    if (rsp_valid) begin
      if (exp_rsp.size() == 0) chk(0, "R3 response with no load outstanding", 1, 0);
      else begin
        hv = exp_rsp.pop_front();
        chk(rsp_data === hv, "R2 R3 load data", rsp_data, hv);
      end
    end
    chk(idle === (mq_a.size() == 0), "R8 idle flag", idle, mq_a.size() == 0);
    // drive this cycle
    mem_rvalid = rv_next;
    mem_rdata  = rv_next ? rv_val : $urandom;
    rv_next    = 0;
    mem_ready  = ($urandom_range(99) < p_ready);
    req_valid  = v;
    req_op     = op;
    req_addr   = a;
    req_wdata  = d;
    #1;
    if (v) begin
      case (op)
        2'd0: begin exp_ready = !busy; chk(req_ready === exp_ready, "R3 load ready", req_ready, exp_ready); end
        2'd3: begin exp_ready = !busy && mq_a.size() == 0; chk(req_ready === exp_ready, "R6 fence ready", req_ready, exp_ready); end
        default: begin exp_ready = !busy && mq_a.size() < DEPTH; chk(req_ready === exp_ready, "R5 store ready", req_ready, exp_ready); end
      endcase
    end
    if (rd_issue) chk(mem_valid && mem_cmd == 2'd0 && mem_addr == rd_q_addr, "R4 read issues first", {mem_valid, mem_cmd}, 3'b100);
    else if (mq_a.size() > 0) chk(mem_valid && mem_cmd != 2'd0, "R1 drain presented", {mem_valid, mem_cmd}, 1);
    else chk(!mem_valid, "R6 memory quiet when nothing pending", mem_valid, 0);
    // load lookup uses the queue as it stands before this edge
    hit = 0; hv = '0;
    if (v && req_ready && op == 2'd0) begin
      for (int i = 0; i < mq_a.size(); i++)
        if (!mq_f[i] && mq_a[i] == a) begin hit = 1; hv = mq_d[i]; end
    end
    fire = mem_valid && mem_ready;
    if (fire && mem_cmd == 2'd0) begin
      rv_next = 1; rv_val = bmem[mem_addr[3:0]]; rd_issue = 0;
    end else if (fire && mq_a.size() > 0) begin
      logic [AW-1:0] ea; logic [DW-1:0] ed; bit ef;
      ea = mq_a.pop_front(); ed = mq_d.pop_front(); ef = mq_f.pop_front();
      chk(mem_addr == ea, "R1 drain address order", mem_addr, ea);
      chk(mem_cmd == (ef ? 2'd2 : 2'd1), "R7 drain command kind", mem_cmd, ef ? 2 : 1);
      if (!ef) begin
        chk(mem_wdata == ed, "R1 drain data order", mem_wdata, ed);
        bmem[mem_addr[3:0]] = mem_wdata;
      end
    end
    if (mem_rvalid) busy = 0;
    if (v && req_ready) begin
      case (op)
        2'd0: begin
          if (hit) begin exp_rsp.push_back(hv); hit_due = 1; end
          else begin exp_rsp.push_back(bmem[a[3:0]]); busy = 1; rd_issue = 1; rd_q_addr = a; end
        end
        2'd1: begin mq_a.push_back(a); mq_d.push_back(d); mq_f.push_back(0); end
        2'd2: begin mq_a.push_back(a); mq_d.push_back('0); mq_f.push_back(1); end
        default: ;
      endcase
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) bmem[i] = 32'hA000_0000 + i;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9: reset state
    chk(idle === 1'b1, "R9 idle after reset", idle, 1);
    chk(mem_valid === 1'b0, "R9 mem_valid after reset", mem_valid, 0);
    chk(rsp_valid === 1'b0, "R9 rsp_valid after reset", rsp_valid, 0);
    chk(req_ready === 1'b1, "R9 load accepted after reset", req_ready, 1);
    // R5: fill with memory stalled, overfill attempts refused
    for (int k = 0; k < 12; k++) step(1, 2'd1, AW'(k % 4), 32'h1000 + k, 0);
    // R2: youngest match while full
    for (int k = 0; k < 4; k++) step(1, 2'd0, AW'(k), '0, 0);
    // R6: fence refused while stores queued
    for (int k = 0; k < 3; k++) step(1, 2'd3, '0, '0, 0);
    // R4: miss overtakes a full queue
    step(1, 2'd0, AW'(9), '0, 0);
    for (int k = 0; k < 3; k++) step(0, 2'd0, '0, '0, 0);
    for (int k = 0; k < 20; k++) step(1, 2'd3, '0, '0, 100);
    // R7: flush is not forwarded
    step(1, 2'd1, AW'(2), 32'hBEEF_0002, 0);
    step(1, 2'd2, AW'(2), '0, 0);
    step(1, 2'd0, AW'(2), '0, 0);
    step(1, 2'd2, AW'(5), '0, 0);
    step(1, 2'd0, AW'(5), '0, 0);
    for (int k = 0; k < 20; k++) step(0, 2'd0, '0, '0, 100);
    // random mixes
    for (int k = 0; k < 4000; k++) begin
      int r = $urandom_range(99);
      logic [1:0] op = (r < 35) ? 2'd0 : (r < 80) ? 2'd1 : (r < 92) ? 2'd2 : 2'd3;
      step($urandom_range(99) < 80, op, AW'($urandom_range(7)), $urandom, 60);
    end
    for (int k = 0; k < 3000; k++) begin
      int r = $urandom_range(99);
      logic [1:0] op = (r < 25) ? 2'd0 : (r < 90) ? 2'd1 : (r < 95) ? 2'd2 : 2'd3;
      step(1, op, AW'($urandom_range(3)), $urandom, 20);
    end
    for (int k = 0; k < 60; k++) step(0, 2'd0, '0, '0, 100);
    chk(exp_rsp.size() == 0, "R3 every load answered", exp_rsp.size(), 0);
    chk(mq_a.size() == 0, "R1 queue fully drained", mq_a.size(), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule